// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block steers a processor core into and out of a dormant low-power state. A sleep request comes from an active-low external pin (falling edge) or from a software force bit (rising edge). The request is not acted on at once: it is raised to the core as a one-cycle, nonmaskable, edge-type interrupt pulse. The core can then run any amount of code before it commits by pulsing `enter_cmd`. From that point the core is held, the block reports that it is dormant, and it stops the oscillator if the crystal option is selected.

A wake event ends the dormant state. It is either the return of the sleep pin to its high level or a rising edge on a dedicated wake input. After a wake event the block counts a restart delay before it releases the core. The delay is short when the clock keeps running during sleep, and long when a stopped crystal has to start up again. When the core is released, a clean-context option can produce a one-cycle pulse that tells the core to discard its saved state. An asynchronous reset aborts any phase and returns the block to normal running.

The states are RUN (normal operation), ENTERING (one cycle in which the core is frozen), DOWN (dormant) and WAKE_COUNT (restart delay). The transitions are:
- RUN→ENTERING on an accepted entry command.
- ENTERING→DOWN on the next cycle.
- DOWN→WAKE_COUNT on a wake event.
- WAKE_COUNT→RUN when the delay counter expires.
- Any state→RUN on reset.

Top module: `pwrdn_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, the outputs are core_hold=0, dormant_ack=0, osc_en=1, sleep_irq=0 and ctx_clear=0 (state RUN).
- R2: In RUN, a falling edge on sleep_req_n or a rising edge on sw_force drives sleep_irq high for exactly one cycle, the cycle after the edge is sampled. The same edges seen in any other state give no pulse.
- R3: A one-cycle enter_cmd sampled in RUN after a request pulse raises core_hold in the next cycle (ENTERING, dormant_ack still 0). An enter_cmd with no request pending leaves core_hold at 0.
- R4: ENTERING lasts one cycle and is followed by DOWN. dormant_ack is high in DOWN and only in DOWN.
- R5: In DOWN, osc_en is 0 if xtal_stop was 1 at the entry command, and 1 otherwise. osc_en is 1 in every other state.
- R6: With xtal_stop=0 captured at entry, a wake event sampled at edge E keeps core_hold high until, and drops it at, edge E+RUN_WAIT (100 by default). A wake event is a rising edge on sleep_req_n or a rising edge on wake_in, and dormant_ack falls at E.
- R7: With xtal_stop=1 captured at entry, a wake event at edge E raises osc_en at E and drops core_hold at edge E+XTAL_WAIT (4096 by default).
- R8: Wake events in RUN or during WAKE_COUNT are ignored: core_hold, dormant_ack and the release time are unchanged.
- R9: ctx_clear is high for exactly the one cycle after core_hold falls at release if ctx_clean was 1 at the entry command. It stays 0 otherwise.
- R10: Pulling rst_n low in DOWN or in WAKE_COUNT immediately forces the R1 output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, also ends power-down |
| sleep_req_n | input | 1 | Active-low sleep pin: falling edge requests, rising edge wakes |
| sw_force | input | 1 | Software force bit, rising edge requests |
| wake_in | input | 1 | Dedicated wake input, rising edge wakes |
| enter_cmd | input | 1 | Core commits to entering the dormant state |
| xtal_stop | input | 1 | 1: stop the crystal while dormant (long restart) |
| ctx_clean | input | 1 | 1: request a clean context on exit |
| sleep_irq | output | 1 | One-cycle nonmaskable sleep interrupt to the core |
| core_hold | output | 1 | Core frozen (ENTERING, DOWN, WAKE_COUNT) |
| dormant_ack | output | 1 | Dormant state reached |
| osc_en | output | 1 | Oscillator / clock enable |
| ctx_clear | output | 1 | One-cycle clean-context pulse at release |

## Verification
Every result is registered once after the input edge that causes it:
- sleep_irq, the rise of core_hold and the fall of dormant_ack appear one cycle after the stimulus is driven.
- dormant_ack rises two cycles after the stimulus.
- core_hold falls RUN_WAIT+1 or XTAL_WAIT+1 cycles after the wake stimulus is driven, and ctx_clear follows in that same cycle.
- A reset takes effect within the same cycle.

Each stimulus task computes these cycle numbers from the requirements and queues each expected value against a cycle index. A monitor running on the falling clock edge compares the outputs only in the scheduled cycle, and it flags any expectation whose cycle has passed.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_ENTERING   = 2'd1,
        ST_DOWN       = 2'd2,
        ST_WAKE_COUNT = 2'd3
    } pds_state_e;

    // indices of the edge detectors in the top level
    localparam int EV_PIN_FALL  = 0;
    localparam int EV_PIN_RISE  = 1;
    localparam int EV_SW_RISE   = 2;
    localparam int EV_WAKE_RISE = 3;
    localparam int EV_COUNT     = 4;

endpackage

// File: rtl/pwrdn_edge_det.sv
module pwrdn_edge_det #(
    parameter bit RISE     = 1'b1,
    parameter bit INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic edge_pulse
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= INIT_VAL;
        end else begin
            sig_q <= sig_in;
        end
    end

    generate
        if (RISE) begin : g_rise
            assign edge_pulse = sig_in & ~sig_q;
        end else begin : g_fall
            assign edge_pulse = ~sig_in & sig_q;
        end
    endgenerate

endmodule

// File: rtl/pwrdn_wake_timer.sv
module pwrdn_wake_timer #(
    parameter int RUN_WAIT  = 100,
    parameter int XTAL_WAIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_mode,
    input  logic count_en,
    output logic done
);

    localparam int CW = $clog2(XTAL_WAIT + 1);
    localparam logic [CW-1:0] SHORT_START = CW'(RUN_WAIT - 1);
    localparam logic [CW-1:0] LONG_START  = CW'(XTAL_WAIT - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= long_mode ? LONG_START : SHORT_START;
        end else if (count_en && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
    import pwrdn_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_evt,
    input  logic       wake_evt,
    input  logic       enter_cmd,
    input  logic       timer_done,
    input  logic       xtal_stop,
    input  logic       ctx_clean,
    output pds_state_e state,
    output logic       timer_load,
    output logic       long_mode,
    output logic       sleep_irq,
    output logic       ctx_clear,
    output logic       core_hold,
    output logic       dormant_ack,
    output logic       osc_en
);

    pds_state_e next_state;
    logic       pending;
    logic       xtal_lat;
    logic       ctx_lat;
    logic       accept_entry;
    logic       release_now;

    assign accept_entry = (state == ST_RUN) && enter_cmd && pending;
    assign release_now  = (state == ST_WAKE_COUNT) && timer_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= next_state;
        end
    end

    // transitions
    always_comb begin
        next_state = state;
        timer_load = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (accept_entry) next_state = ST_ENTERING;
            end
            ST_ENTERING: begin
                next_state = ST_DOWN;
            end
            ST_DOWN: begin
                if (wake_evt) begin
                    next_state = ST_WAKE_COUNT;
                    timer_load = 1'b1;
                end
            end
            ST_WAKE_COUNT: begin
                if (timer_done) next_state = ST_RUN;
            end
            default: next_state = ST_RUN;
        endcase
    end

    // request, configuration capture and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            xtal_lat  <= 1'b0;
            ctx_lat   <= 1'b0;
            sleep_irq <= 1'b0;
            ctx_clear <= 1'b0;
        end else begin
            sleep_irq <= (state == ST_RUN) && req_evt;
            ctx_clear <= release_now && ctx_lat;
            if (accept_entry) begin
                pending  <= 1'b0;
                xtal_lat <= xtal_stop;
                ctx_lat  <= ctx_clean;
            end else if ((state == ST_RUN) && req_evt) begin
                pending <= 1'b1;
            end
        end
    end

    assign long_mode = xtal_lat;

    // state-decoded outputs
    always_comb begin
        core_hold   = 1'b1;
        dormant_ack = 1'b0;
        osc_en      = 1'b1;
        unique case (state)
            ST_RUN:        core_hold = 1'b0;
            ST_ENTERING:   core_hold = 1'b1;
            ST_DOWN: begin
                dormant_ack = 1'b1;
                osc_en      = ~xtal_lat;
            end
            ST_WAKE_COUNT: core_hold = 1'b1;
            default:       core_hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwrdn_sequencer.sv
module pwrdn_sequencer
    import pwrdn_seq_pkg::*;
#(
    parameter int RUN_WAIT  = 100,
    parameter int XTAL_WAIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_n,
    input  logic sw_force,
    input  logic wake_in,
    input  logic enter_cmd,
    input  logic xtal_stop,
    input  logic ctx_clean,
    output logic sleep_irq,
    output logic core_hold,
    output logic dormant_ack,
    output logic osc_en,
    output logic ctx_clear
);

    localparam logic [EV_COUNT-1:0] RISE_SEL = 4'b1110;
    localparam logic [EV_COUNT-1:0] INIT_SEL = 4'b0011;

    logic [EV_COUNT-1:0] ev_src;
    logic [EV_COUNT-1:0] ev_hit;
    logic       req_evt;
    logic       wake_evt;
    logic       timer_load;
    logic       long_mode;
    logic       timer_done;
    pds_state_e state;

    assign ev_src = {wake_in, sw_force, sleep_req_n, sleep_req_n};

    generate
        for (genvar i = 0; i < EV_COUNT; i++) begin : g_edge
            pwrdn_edge_det #(
                .RISE     (RISE_SEL[i]),
                .INIT_VAL (INIT_SEL[i])
            ) u_edge (
                .clk        (clk),
                .rst_n      (rst_n),
                .sig_in     (ev_src[i]),
                .edge_pulse (ev_hit[i])
            );
        end
    endgenerate

    assign req_evt  = ev_hit[EV_PIN_FALL] | ev_hit[EV_SW_RISE];
    assign wake_evt = ev_hit[EV_PIN_RISE] | ev_hit[EV_WAKE_RISE];

    pwrdn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_evt     (req_evt),
        .wake_evt    (wake_evt),
        .enter_cmd   (enter_cmd),
        .timer_done  (timer_done),
        .xtal_stop   (xtal_stop),
        .ctx_clean   (ctx_clean),
        .state       (state),
        .timer_load  (timer_load),
        .long_mode   (long_mode),
        .sleep_irq   (sleep_irq),
        .ctx_clear   (ctx_clear),
        .core_hold   (core_hold),
        .dormant_ack (dormant_ack),
        .osc_en      (osc_en)
    );

    pwrdn_wake_timer #(
        .RUN_WAIT  (RUN_WAIT),
        .XTAL_WAIT (XTAL_WAIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (timer_load),
        .long_mode (long_mode),
        .count_en  (state == ST_WAKE_COUNT),
        .done      (timer_done)
    );

endmodule

// File: rtl/pwrdn_sequencer_chk.sv
module pwrdn_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_irq,
    input logic core_hold,
    input logic dormant_ack,
    input logic osc_en,
    input logic ctx_clear
);

    // R2: the interrupt is a single-cycle pulse
    a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_irq |=> !sleep_irq);

    // R3: the hold rises while the dormant indication is still low
    a_r3_hold_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_hold) |-> !dormant_ack);

    // R4: dormant only after a frozen cycle
    a_r4_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dormant_ack) |-> $past(core_hold));

    // R5: the oscillator runs whenever the core runs
    a_r5_osc_on_run: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |-> osc_en);

    // R6: leaving the dormant state goes into the restart count, not to run
    a_r6_wake_counts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dormant_ack) |-> core_hold);

    // R9: the clean-context pulse comes only at release
    a_r9_ctx_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |-> $fell(core_hold));

    // R9: the clean-context pulse lasts one cycle
    a_r9_ctx_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> !ctx_clear);

endmodule

bind pwrdn_sequencer pwrdn_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_irq   (sleep_irq),
    .core_hold   (core_hold),
    .dormant_ack (dormant_ack),
    .osc_en      (osc_en),
    .ctx_clear   (ctx_clear)
);

// File: tb/tb_pwrdn_sequencer.sv
module tb_pwrdn_sequencer;

    localparam int RUN_WAIT  = 100;
    localparam int XTAL_WAIT = 4096;

    localparam int S_HOLD = 0;
    localparam int S_ACK  = 1;
    localparam int S_OSC  = 2;
    localparam int S_IRQ  = 3;
    localparam int S_CTX  = 4;

    typedef struct {
        int    cyc;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req_n = 1'b1;
    logic sw_force = 1'b0;
    logic wake_in = 1'b0;
    logic enter_cmd = 1'b0;
    logic xtal_stop = 1'b0;
    logic ctx_clean = 1'b0;
    logic sleep_irq, core_hold, dormant_ack, osc_en, ctx_clear;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_flag = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pwrdn_sequencer #(
        .RUN_WAIT  (RUN_WAIT),
        .XTAL_WAIT (XTAL_WAIT)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_n (sleep_req_n),
        .sw_force    (sw_force),
        .wake_in     (wake_in),
        .enter_cmd   (enter_cmd),
        .xtal_stop   (xtal_stop),
        .ctx_clean   (ctx_clean),
        .sleep_irq   (sleep_irq),
        .core_hold   (core_hold),
        .dormant_ack (dormant_ack),
        .osc_en      (osc_en),
        .ctx_clear   (ctx_clear)
    );

    function automatic logic pick(int s);
        case (s)
            S_HOLD:  return core_hold;
            S_ACK:   return dormant_ack;
            S_OSC:   return osc_en;
            S_IRQ:   return sleep_irq;
            default: return ctx_clear;
        endcase
    endfunction

    function automatic string sname(int s);
        case (s)
            S_HOLD:  return "core_hold";
            S_ACK:   return "dormant_ack";
            S_OSC:   return "osc_en";
            S_IRQ:   return "sleep_irq";
            default: return "ctx_clear";
        endcase
    endfunction

    // driver side: queue an expectation, kept sorted by cycle
    task automatic expect_at(int at, int s, logic v, string tag);
        exp_t e;
        int   pos;
        e.cyc = at; e.sig = s; e.val = v; e.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > at) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, e);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            e = sb.pop_front();
            n_cmp++;
            if (e.cyc < cyc) begin
                n_bad++;
                $display("FAIL %s: %s expectation for cycle %0d missed (now %0d)",
                         e.tag, sname(e.sig), e.cyc, cyc);
            end else if (pick(e.sig) !== e.val) begin
                n_bad++;
                $display("FAIL %s: %s at cycle %0d actual %b expected %b",
                         e.tag, sname(e.sig), cyc, pick(e.sig), e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        step(3);
        // R1: reset values, checked before and after release
        expect_at(cyc, S_HOLD, 1'b0, "R1");
        expect_at(cyc, S_ACK,  1'b0, "R1");
        step(1);
        rst_n = 1'b1;
        expect_at(cyc, S_HOLD, 1'b0, "R1");
        expect_at(cyc, S_ACK,  1'b0, "R1");
        expect_at(cyc, S_OSC,  1'b1, "R1");
        expect_at(cyc, S_IRQ,  1'b0, "R1");
        expect_at(cyc, S_CTX,  1'b0, "R1");
        step(2);

        // R3: entry command without a pending request is ignored
        enter_cmd = 1'b1; k = cyc;
        expect_at(k + 1, S_HOLD, 1'b0, "R3");
        step(1); enter_cmd = 1'b0;
        step(2);

        // R8: wake in RUN ignored
        wake_in = 1'b1; k = cyc;
        expect_at(k + 1, S_HOLD, 1'b0, "R8");
        expect_at(k + 2, S_ACK,  1'b0, "R8");
        step(1); wake_in = 1'b0;
        step(2);

        // R2: pin falling edge raises one-cycle interrupt
        sleep_req_n = 1'b0; k = cyc;
        expect_at(k + 1, S_IRQ, 1'b1, "R2");
        expect_at(k + 2, S_IRQ, 1'b0, "R2");
        step(3);

        // R3, R4, R5: commit entry, clock left running
        enter_cmd = 1'b1; k = cyc;
        expect_at(k + 1, S_HOLD, 1'b1, "R3");
        expect_at(k + 1, S_ACK,  1'b0, "R3");
        expect_at(k + 2, S_ACK,  1'b1, "R4");
        expect_at(k + 2, S_OSC,  1'b1, "R5");
        step(1); enter_cmd = 1'b0;
        step(4);

        // R2: request edge while dormant gives no pulse
        sw_force = 1'b1; k = cyc;
        expect_at(k + 1, S_IRQ, 1'b0, "R2");
        expect_at(k + 1, S_ACK, 1'b1, "R4");
        step(1); sw_force = 1'b0;
        step(2);

        // R6: wake by pin return, short restart
        sleep_req_n = 1'b1; k = cyc;
        expect_at(k + 1, S_ACK,  1'b0, "R6");
        expect_at(k + 1, S_HOLD, 1'b1, "R6");
        expect_at(k + RUN_WAIT, S_HOLD, 1'b1, "R6");
        expect_at(k + RUN_WAIT + 1, S_HOLD, 1'b0, "R6");
        expect_at(k + RUN_WAIT + 1, S_CTX,  1'b0, "R9");
        step(10);
        // R8: extra wake during the count does not change release time
        wake_in = 1'b1;
        expect_at(cyc + 1, S_ACK, 1'b0, "R8");
        step(1); wake_in = 1'b0;
        step(RUN_WAIT);

        // R2, R5, R7, R9: software request, crystal stopped, clean exit
        xtal_stop = 1'b1; ctx_clean = 1'b1;
        sw_force = 1'b1; k = cyc;
        expect_at(k + 1, S_IRQ, 1'b1, "R2");
        expect_at(k + 2, S_IRQ, 1'b0, "R2");
        step(1); sw_force = 1'b0;
        step(2);
        enter_cmd = 1'b1; k = cyc;
        expect_at(k + 2, S_ACK, 1'b1, "R4");
        expect_at(k + 2, S_OSC, 1'b0, "R5");
        step(1); enter_cmd = 1'b0;
        xtal_stop = 1'b0; ctx_clean = 1'b0;
        expect_at(cyc + 2, S_OSC, 1'b0, "R5");
        step(3);
        wake_in = 1'b1; k = cyc;
        expect_at(k + 1, S_OSC, 1'b1, "R7");
        expect_at(k + XTAL_WAIT, S_HOLD, 1'b1, "R7");
        expect_at(k + XTAL_WAIT + 1, S_HOLD, 1'b0, "R7");
        expect_at(k + XTAL_WAIT, S_CTX, 1'b0, "R9");
        expect_at(k + XTAL_WAIT + 1, S_CTX, 1'b1, "R9");
        expect_at(k + XTAL_WAIT + 2, S_CTX, 1'b0, "R9");
        step(1); wake_in = 1'b0;
        step(XTAL_WAIT + 4);

        // R10: reset while dormant
        sleep_req_n = 1'b0;
        step(3);
        enter_cmd = 1'b1;
        step(1); enter_cmd = 1'b0;
        step(3);
        expect_at(cyc, S_ACK, 1'b1, "R10");
        step(1);
        rst_n = 1'b0;
        expect_at(cyc, S_HOLD, 1'b0, "R10");
        expect_at(cyc, S_ACK,  1'b0, "R10");
        expect_at(cyc, S_OSC,  1'b1, "R10");
        step(2);
        sleep_req_n = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(2);

        // R10: reset during the restart count
        xtal_stop = 1'b1;
        sw_force = 1'b1;
        step(1); sw_force = 1'b0;
        step(2);
        enter_cmd = 1'b1;
        step(1); enter_cmd = 1'b0;
        step(3);
        wake_in = 1'b1;
        step(1); wake_in = 1'b0;
        step(50);
        expect_at(cyc, S_HOLD, 1'b1, "R7");
        step(1);
        rst_n = 1'b0;
        expect_at(cyc, S_HOLD, 1'b0, "R10");
        expect_at(cyc, S_CTX,  1'b0, "R10");
        step(2);
        rst_n = 1'b1;
        expect_at(cyc + 5, S_HOLD, 1'b0, "R10");
        step(10);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule